// File: doc/BRIEF.md
# Receiver Automatic Gain Control Loop

This block closes the digital side of a receiver gain loop. It takes magnitude samples from the IF path, each marked by a sample strobe. It averages them over a window of programmable length and compares the average with a programmable target magnitude. At the end of each window it adds the difference to the current gain code. Each new gain code is clamped between zero and a programmable ceiling. After every gain change the loop ignores samples for a programmable blanking time, so that the effect of the new gain can reach the detector before the next measurement.

At the end of each averaging window, the block gives a signal-strength estimate together with a one-cycle strobe. The estimate combines the measured level with the gain that was in effect during the window. A settled flag rises at the first window that ends without a gain change. Dropping the receive enable abandons all loop activity. Raising it again reloads the gain ceiling and restarts a fixed settling delay, which covers the demodulator start-up. Two freeze options hold the gain: one holds it from the point where a sync pulse is seen, and the other holds it all the time.

The control state machine has four states. IDLE means the receiver is off. SETTLE is the start-up delay, MEASURE is the averaging window, and BLANK is the post-change wait. The transitions are as follows:
- IDLE→SETTLE when receive enable is high.
- SETTLE→MEASURE after the settling strobes.
- MEASURE→BLANK when a window ends with a gain change.
- MEASURE→MEASURE when a window ends without one.
- BLANK→MEASURE after the blanking strobes.
- Any state→IDLE when receive enable is low.

Top module: `agc_loop`

## Requirements
- R1: After reset, gain_code, rssi_val, rssi_valid and settled are all 0.
- R2: On the clock edge that first samples rx_en high, gain_code loads cfg_gain_max. The next SETTLE_SAMPLES accepted strobes (default 12) are discarded: they produce no window and no gain change.
- R3: An averaging window spans exactly 8·2^cfg_flen accepted strobes. rssi_valid is high for exactly one cycle, on the cycle after the edge that takes the window's last strobe.
- R4: At the end of a window, the average is floor(sum/length). The new gain is clamp(gain + cfg_target − average, 0, cfg_gain_max).
- R5: After a window that changes the gain, the next 8·(cfg_wait+1) accepted strobes are discarded before the next window begins.
- R6: After a window that leaves the gain unchanged, the next window begins with the very next accepted strobe.
- R7: rssi_val equals average + (2^GAIN_W − 1 − g), where g is the gain code in effect during that window (63 − g with the defaults).
- R8: settled rises at the end of the first window that leaves the gain unchanged. It stays high while rx_en stays high, even if later windows change the gain.
- R9: With cfg_freeze = 1, the loop behaves normally until a sync_found pulse. After it, the gain holds, windows keep producing rssi strobes, and no blanking wait is inserted.
- R10: With cfg_freeze = 2 or 3, the gain never changes after the entry load. Every window still strobes rssi and ends without blanking.
- R11: While rx_en is low, strobes are ignored and settled is 0. A partly filled window is discarded. Raising rx_en again reloads the gain and restarts the settling delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| rx_en | input | 1 | Receive enable |
| sync_found | input | 1 | One-cycle pulse when the demodulator finds sync |
| smp_valid | input | 1 | Sample strobe |
| smp_mag | input | MAG_W | Magnitude sample |
| cfg_target | input | MAG_W | Target average magnitude |
| cfg_flen | input | FLEN_W | Window length exponent |
| cfg_wait | input | WAIT_W | Blanking length field |
| cfg_gain_max | input | GAIN_W | Gain ceiling and entry gain |
| cfg_freeze | input | 2 | 0 normal, 1 hold after sync, 2/3 hold always |
| gain_code | output | GAIN_W | Current gain code |
| rssi_valid | output | 1 | One-cycle strobe at each window end |
| rssi_val | output | max(MAG_W,GAIN_W)+1 | Signal-strength estimate |
| settled | output | 1 | Loop has completed a window without gain change |

## Verification
Every window result (gain_code, rssi_val, rssi_valid and settled) appears on the clock edge that accepts the last strobe of the window. The loaded entry gain appears one edge after rx_en rises. The bench drives inputs on falling edges and reads results at the next falling edge, which is the first point where those results are visible. The bench also counts rssi_valid pulses at rising edges. This shows that no pulse arrives before the last strobe of a window, or during the settling and blanking spans.

// File: rtl/agc_pkg.sv
package agc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_MEASURE = 2'd2,
        ST_BLANK   = 2'd3
    } agc_state_t;

    localparam logic [1:0] FRZ_NONE    = 2'd0;
    localparam logic [1:0] FRZ_ON_SYNC = 2'd1;

endpackage

// File: rtl/agc_sample_counter.sv
module agc_sample_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);

    logic [CNT_W-1:0] count;

    assign last = step && (count == (limit - CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr || last) begin
            count <= '0;
        end else if (step) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/agc_accum.sv
module agc_accum #(
    parameter int MAG_W  = 8,
    parameter int FLEN_W = 2,
    parameter int ACC_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic              dump,
    input  logic [MAG_W-1:0]  sample,
    input  logic [FLEN_W-1:0] flen,
    output logic [MAG_W-1:0]  avg
);

    localparam int SHW = $clog2((1 << FLEN_W) + 3);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum_now;
    logic [SHW-1:0]   shamt;

    always_comb begin
        sum_now = acc + ACC_W'(sample);
        shamt   = SHW'(3) + SHW'(flen);
        avg     = MAG_W'(sum_now >> shamt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr || dump) begin
            acc <= '0;
        end else if (add) begin
            acc <= sum_now;
        end
    end

endmodule

// File: rtl/agc_gain_step.sv
module agc_gain_step #(
    parameter int MAG_W  = 8,
    parameter int GAIN_W = 6,
    parameter int RSSI_W = 9
) (
    input  logic [GAIN_W-1:0] gain_cur,
    input  logic [MAG_W-1:0]  avg,
    input  logic [MAG_W-1:0]  target,
    input  logic [GAIN_W-1:0] gain_max,
    input  logic              hold,
    output logic [GAIN_W-1:0] gain_next,
    output logic              change,
    output logic [RSSI_W-1:0] rssi
);

    localparam int WIDE  = (MAG_W > GAIN_W) ? MAG_W : GAIN_W;
    localparam int SUM_W = WIDE + 2;
    localparam logic [GAIN_W-1:0] GAIN_TOP = '1;

    logic signed [SUM_W-1:0] s_gain;
    logic signed [SUM_W-1:0] s_tgt;
    logic signed [SUM_W-1:0] s_avg;
    logic signed [SUM_W-1:0] s_max;
    logic signed [SUM_W-1:0] s_sum;
    logic        [GAIN_W-1:0] g_clamp;

    always_comb begin
        s_gain = signed'({{(SUM_W-GAIN_W){1'b0}}, gain_cur});
        s_max  = signed'({{(SUM_W-GAIN_W){1'b0}}, gain_max});
        s_tgt  = signed'({{(SUM_W-MAG_W){1'b0}}, target});
        s_avg  = signed'({{(SUM_W-MAG_W){1'b0}}, avg});
        s_sum  = s_gain + (s_tgt - s_avg);

        if (s_sum[SUM_W-1]) begin
            g_clamp = '0;
        end else if (s_sum > s_max) begin
            g_clamp = gain_max;
        end else begin
            g_clamp = GAIN_W'(s_sum);
        end

        change    = !hold && (g_clamp != gain_cur);
        gain_next = change ? g_clamp : gain_cur;
        rssi      = RSSI_W'(avg) + RSSI_W'(GAIN_TOP - gain_cur);
    end

endmodule

// File: rtl/agc_loop.sv
module agc_loop
    import agc_pkg::*;
#(
    parameter int MAG_W          = 8,
    parameter int GAIN_W         = 6,
    parameter int FLEN_W         = 2,
    parameter int WAIT_W         = 2,
    parameter int SETTLE_SAMPLES = 12
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     rx_en,
    input  logic                                     sync_found,
    input  logic                                     smp_valid,
    input  logic [MAG_W-1:0]                         smp_mag,
    input  logic [MAG_W-1:0]                         cfg_target,
    input  logic [FLEN_W-1:0]                        cfg_flen,
    input  logic [WAIT_W-1:0]                        cfg_wait,
    input  logic [GAIN_W-1:0]                        cfg_gain_max,
    input  logic [1:0]                               cfg_freeze,
    output logic [GAIN_W-1:0]                        gain_code,
    output logic                                     rssi_valid,
    output logic [((MAG_W > GAIN_W) ? MAG_W : GAIN_W):0] rssi_val,
    output logic                                     settled
);

    localparam int WIDE     = (MAG_W > GAIN_W) ? MAG_W : GAIN_W;
    localparam int RSSI_W   = WIDE + 1;
    localparam int WIN_MAX  = 8 << ((1 << FLEN_W) - 1);
    localparam int WAIT_MAX = 8 << WAIT_W;
    localparam int SPAN_MAX = (WIN_MAX > WAIT_MAX) ? WIN_MAX : WAIT_MAX;
    localparam int CNT_MAX  = (SPAN_MAX > SETTLE_SAMPLES) ? SPAN_MAX : SETTLE_SAMPLES;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int ACC_W    = MAG_W + 3 + (1 << FLEN_W) - 1;

    agc_state_t state;
    agc_state_t state_nxt;

    logic              stb;
    logic              cnt_clr;
    logic              cnt_last;
    logic [CNT_W-1:0]  cnt_limit;
    logic [CNT_W-1:0]  win_len;
    logic [CNT_W-1:0]  wait_len;
    logic              acc_add;
    logic              acc_clr;
    logic              win_end;
    logic              load_gain;
    logic [MAG_W-1:0]  avg;
    logic              hold;
    logic              sync_seen;
    logic [GAIN_W-1:0] gain_next;
    logic              gain_chg;
    logic [RSSI_W-1:0] rssi_calc;

    assign stb      = smp_valid && rx_en;
    assign win_len  = CNT_W'(8) << cfg_flen;
    assign wait_len = CNT_W'({cfg_wait, 3'b000}) + CNT_W'(8);
    assign hold     = cfg_freeze[1] || ((cfg_freeze == FRZ_ON_SYNC) && sync_seen);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (rx_en) state_nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (cnt_last) state_nxt = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (cnt_last && gain_chg) state_nxt = ST_BLANK;
            end
            ST_BLANK: begin
                if (cnt_last) state_nxt = ST_MEASURE;
            end
        endcase
        if (!rx_en) state_nxt = ST_IDLE;
    end

    // Control outputs decoded from the state
    always_comb begin
        cnt_limit = win_len;
        acc_add   = 1'b0;
        acc_clr   = 1'b1;
        win_end   = 1'b0;
        load_gain = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load_gain = rx_en;
            end
            ST_SETTLE: begin
                cnt_limit = CNT_W'(SETTLE_SAMPLES);
            end
            ST_MEASURE: begin
                cnt_limit = win_len;
                acc_add   = stb;
                acc_clr   = !rx_en;
                win_end   = cnt_last;
            end
            ST_BLANK: begin
                cnt_limit = wait_len;
            end
        endcase
        cnt_clr = !rx_en || (state == ST_IDLE);
    end

    agc_sample_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .step  (stb),
        .limit (cnt_limit),
        .last  (cnt_last)
    );

    agc_accum #(
        .MAG_W  (MAG_W),
        .FLEN_W (FLEN_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acc_clr),
        .add    (acc_add),
        .dump   (win_end),
        .sample (smp_mag),
        .flen   (cfg_flen),
        .avg    (avg)
    );

    agc_gain_step #(
        .MAG_W  (MAG_W),
        .GAIN_W (GAIN_W),
        .RSSI_W (RSSI_W)
    ) u_step (
        .gain_cur  (gain_code),
        .avg       (avg),
        .target    (cfg_target),
        .gain_max  (cfg_gain_max),
        .hold      (hold),
        .gain_next (gain_next),
        .change    (gain_chg),
        .rssi      (rssi_calc)
    );

    // Gain register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_code <= '0;
        end else if (load_gain) begin
            gain_code <= cfg_gain_max;
        end else if (win_end && gain_chg) begin
            gain_code <= gain_next;
        end
    end

    // Signal-strength report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rssi_valid <= 1'b0;
            rssi_val   <= '0;
        end else begin
            rssi_valid <= win_end;
            if (win_end) rssi_val <= rssi_calc;
        end
    end

    // Settled flag and sync capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settled   <= 1'b0;
            sync_seen <= 1'b0;
        end else if (!rx_en) begin
            settled   <= 1'b0;
            sync_seen <= 1'b0;
        end else begin
            if (win_end && !gain_chg) settled <= 1'b1;
            if (sync_found) sync_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/agc_loop_chk.sv
module agc_loop_chk
    import agc_pkg::*;
#(
    parameter int GAIN_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic [1:0]        cfg_freeze,
    input logic [GAIN_W-1:0] cfg_gain_max,
    input logic [GAIN_W-1:0] gain_code,
    input logic              rssi_valid,
    input logic              settled,
    input agc_state_t        state,
    input logic              win_end,
    input logic              gain_chg,
    input logic              sync_seen
);

    // R3
    rssi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rssi_valid |=> !rssi_valid);

    // R8
    settled_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && rx_en) |=> settled);

    // R11
    rx_drop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!settled && state == ST_IDLE));

    // R5
    blank_after_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && gain_chg) |=> (state == ST_BLANK));

    // R6
    measure_again_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && !gain_chg) |=> (state == ST_MEASURE));

    // R10
    freeze_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && rx_en && cfg_freeze[1]) |=> $stable(gain_code));

    // R9
    freeze_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && rx_en && cfg_freeze == 2'd1 && sync_seen) |=> $stable(gain_code));

    // R4
    gain_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $stable(cfg_gain_max)) |-> (gain_code <= cfg_gain_max));

endmodule

bind agc_loop agc_loop_chk #(
    .GAIN_W (GAIN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_en        (rx_en),
    .cfg_freeze   (cfg_freeze),
    .cfg_gain_max (cfg_gain_max),
    .gain_code    (gain_code),
    .rssi_valid   (rssi_valid),
    .settled      (settled),
    .state        (state),
    .win_end      (win_end),
    .gain_chg     (gain_chg),
    .sync_seen    (sync_seen)
);

// File: tb/agc_loop_tb_top.sv
module agc_loop_tb_top;

    localparam int SETTLE = 12;
    localparam int GTOP   = 63;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       sync_found = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_mag = '0;
    logic [7:0] cfg_target = '0;
    logic [1:0] cfg_flen = '0;
    logic [1:0] cfg_wait = '0;
    logic [5:0] cfg_gain_max = '0;
    logic [1:0] cfg_freeze = '0;
    logic [5:0] gain_code;
    logic       rssi_valid;
    logic [8:0] rssi_val;
    logic       settled;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int cycles = 0;

    agc_loop dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_en        (rx_en),
        .sync_found   (sync_found),
        .smp_valid    (smp_valid),
        .smp_mag      (smp_mag),
        .cfg_target   (cfg_target),
        .cfg_flen     (cfg_flen),
        .cfg_wait     (cfg_wait),
        .cfg_gain_max (cfg_gain_max),
        .cfg_freeze   (cfg_freeze),
        .gain_code    (gain_code),
        .rssi_valid   (rssi_valid),
        .rssi_val     (rssi_val),
        .settled      (settled)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rssi_valid) pulses <= pulses + 1;
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampg(int v, int mx);
        if (v < 0) return 0;
        if (v > mx) return mx;
        return v;
    endfunction

    task automatic send1(int mag);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_mag   = 8'(mag);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic rx_on(int exp_gain);
        @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
        chk("R2 entry gain load", int'(gain_code), exp_gain);
    endtask

    task automatic rx_off();
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R11 settled cleared", int'(settled), 0);
    endtask

    task automatic junk(int n, string tag);
        int p0;
        int g0;
        @(negedge clk);
        p0 = pulses;
        g0 = int'(gain_code);
        for (int i = 0; i < n; i++) send1(0);
        chk({tag, " no pulse"}, pulses - p0 + int'(rssi_valid), 0);
        chk({tag, " gain held"}, int'(gain_code), g0);
    endtask

    task automatic win2(int a, int b, int n, int eg, int er, string tag);
        int p0;
        @(negedge clk);
        p0 = pulses;
        for (int i = 0; i < n - 1; i++) send1((i % 2) ? b : a);
        chk("R3 no early window end", pulses - p0 + int'(rssi_valid), 0);
        send1(((n - 1) % 2) ? b : a);
        chk("R3 rssi strobe at window end", int'(rssi_valid), 1);
        chk({tag, " gain"}, int'(gain_code), eg);
        chk("R7 rssi value", int'(rssi_val), er);
    endtask

    task automatic win(int mag, int n, int eg, int er, string tag);
        win2(mag, mag, n, eg, er, tag);
    endtask

    initial begin
        int w;
        int wl;
        int a;
        int g1;
        int g2;

        repeat (3) @(negedge clk);
        chk("R1 gain reset", int'(gain_code), 0);
        chk("R1 settled reset", int'(settled), 0);
        chk("R1 rssi_valid reset", int'(rssi_valid), 0);
        chk("R1 rssi_val reset", int'(rssi_val), 0);
        rst_n = 1'b1;

        // R11: strobes while receive is off have no effect
        cfg_target = 8'd100; cfg_gain_max = 6'd40;
        junk(70, "R11 rx off");
        chk("R11 settled while off", int'(settled), 0);

        // Sweep window length and blanking length (R2 R3 R4 R5 R6 R7 R8)
        for (int f = 0; f < 4; f++) begin
            for (int wv = 0; wv < 4; wv++) begin
                cfg_flen = 2'(f); cfg_wait = 2'(wv); cfg_freeze = 2'd0;
                cfg_target = 8'd100; cfg_gain_max = 6'd40;
                w  = 8 << f;
                wl = 8 * (wv + 1);
                a  = 105 + 3 * (f * 4 + wv);
                g1 = clampg(40 + 100 - a, 40);
                g2 = clampg(g1 + 5, 40);
                rx_on(40);
                junk(SETTLE, "R2 settle");
                win(a, w, g1, a + GTOP - 40, "R4 first update");
                chk("R8 not settled after change", int'(settled), 0);
                junk(wl, "R5 blanking");
                win(100, w, g1, 100 + GTOP - g1, "R6 on target");
                chk("R8 settled", int'(settled), 1);
                win(95, w, g2, 95 + GTOP - g1, "R6 back-to-back window");
                chk("R8 settled sticky", int'(settled), 1);
                rx_off();
                chk("R11 gain kept while off", int'(gain_code), g2);
            end
        end

        // Clamp at ceiling and zero, floor of the average (R4 R8)
        cfg_flen = 2'd0; cfg_wait = 2'd0; cfg_gain_max = 6'd20;
        rx_on(20);
        junk(SETTLE, "R2 settle");
        win(60, 8, 20, 60 + GTOP - 20, "R4 clamp at ceiling");
        chk("R8 settled on first window", int'(settled), 1);
        win(120, 8, 0, 120 + GTOP - 20, "R4 clamp at zero");
        junk(8, "R5 blanking");
        win2(97, 98, 8, 3, 97 + GTOP - 0, "R4 floor average");
        rx_off();

        // Freeze always (R10)
        cfg_freeze = 2'd2; cfg_gain_max = 6'd30;
        rx_on(30);
        junk(SETTLE, "R2 settle");
        win(150, 8, 30, 150 + GTOP - 30, "R10 frozen high input");
        chk("R10 settled", int'(settled), 1);
        win(50, 8, 30, 50 + GTOP - 30, "R10 frozen low input");
        rx_off();
        cfg_freeze = 2'd3;
        rx_on(30);
        junk(SETTLE, "R2 settle");
        win(10, 8, 30, 10 + GTOP - 30, "R10 freeze code 3");
        rx_off();

        // Freeze on sync (R9)
        cfg_freeze = 2'd1;
        rx_on(30);
        junk(SETTLE, "R2 settle");
        win(110, 8, 20, 110 + GTOP - 30, "R9 updates before sync");
        junk(8, "R5 blanking");
        @(negedge clk); sync_found = 1'b1;
        @(negedge clk); sync_found = 1'b0;
        win(150, 8, 20, 150 + GTOP - 20, "R9 held after sync");
        chk("R9 settled", int'(settled), 1);
        win(60, 8, 20, 60 + GTOP - 20, "R9 no blanking after sync");
        rx_off();

        // Receive dropped mid-window (R11)
        cfg_freeze = 2'd0; cfg_flen = 2'd1; cfg_gain_max = 6'd40;
        rx_on(40);
        junk(SETTLE, "R2 settle");
        win(120, 16, 20, 120 + GTOP - 40, "R4 update");
        junk(8, "R5 blanking");
        for (int i = 0; i < 5; i++) send1(0);
        rx_off();
        rx_on(40);
        junk(SETTLE, "R11 settle restarted");
        win(110, 16, 30, 110 + GTOP - 40, "R11 partial window discarded");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule